// File: doc/BRIEF.md
# OSD Character Row Pixel Serializer

This block produces one scan line of an on-screen-display character row as a serial stream of one-bit OSD pixels. A start pulse begins the line. The block then walks the characters of the row from left to right. For each character it requests that character's 12-bit font slice through an index/data handshake. It then shifts the slice out one pixel for each pixel-clock enable.

Each of the first 32 columns is normal width (12 pixels) or double width (24 pixels), as its bit in a per-column mask selects. In a double-width column every font pixel is repeated. Characters beyond the first 32 are always normal width. The line ends with a one-cycle line-done pulse, and the block returns to idle to wait for the next start.

Top module: `osd_row_serializer`

## Requirements
- R1: On `line_start` in idle, the block captures `dbl_mask` and `char_count`. Changes on those inputs while a line is running do not affect that line, but they are used by the next line.
- R2: A column whose mask bit is 0 emits exactly 12 pixels. They are the font slice bits from bit 11 (leftmost) down to bit 0.
- R3: A column whose mask bit is 1 emits exactly 24 pixels. Each slice bit, from bit 11 down to bit 0, appears in two consecutive pixels.
- R4: Columns with index 32 or higher always emit 12 pixels, whatever the mask holds.
- R5: Before a column's first pixel, `font_req` is high and `font_idx` holds the column index, counting from 0, until `font_valid` is sampled high together with `font_data`. No further pixels appear while the block waits.
- R6: Each `pix_en` cycle in the emitting phase produces one pixel: `pix_valid` is high in the following cycle. `pix_out` is 0 whenever `pix_valid` is 0.
- R7: `line_done` is high for exactly one cycle, in the same cycle as the line's last pixel. In the next cycle the block is idle, with no request and no pixel.
- R8: A character count of 0 produces no fetch and no pixels. `line_done` is high in the cycle right after the start pulse.
- R9: A `line_start` pulse while a line is running is ignored. No extra pixels or fetches result.
- R10: Synchronous reset `rst` clears all outputs to 0, returns the block to idle and drops a partly emitted line, so no `line_done` follows for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable; one pixel advance per high cycle |
| line_start | input | 1 | Starts a line when the block is idle |
| dbl_mask | input | MASK_W | Double-width select, bit n for column n |
| char_count | input | CNT_W | Number of characters on the row |
| font_req | output | 1 | Font slice request |
| font_idx | output | CNT_W | Column index of the requested slice |
| font_data | input | FONT_W | Font slice, bit FONT_W-1 leftmost |
| font_valid | input | 1 | Qualifies font_data while font_req is high |
| pix_out | output | 1 | OSD pixel value |
| pix_valid | output | 1 | Pixel strobe |
| line_done | output | 1 | One-cycle end-of-line pulse |

## Verification
Some properties hold on every cycle, and the bound checker tracks those. It checks that a pixel only follows an enable and that the pixel is low when not valid. It checks that the request index holds while the block waits and that no pixel appears during a fetch wait. It also checks that line-done is a single pulse followed by an idle cycle. Other behaviours need whole scenarios, so only the bench's scoreboard can show them: column widths taken from the mask, the fixed width beyond column 32, bit order, capture of the mask and count at the start pulse, ignored restarts, zero-length lines and an aborted line.

// File: rtl/osd_ser_pkg.sv
package osd_ser_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_SHIFT = 2'd2,
      ST_DONE  = 2'd3
   } ser_state_t;
endpackage

// File: rtl/osd_ser_ctrl.sv
module osd_ser_ctrl
   import osd_ser_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             line_start,
   input  logic [CNT_W-1:0] char_count,
   input  logic             font_valid,
   input  logic             col_end,
   output logic [CNT_W-1:0] col,
   output logic             cap,
   output logic             load,
   output logic             active,
   output logic             font_req,
   output logic             line_done
);
   ser_state_t       state;
   logic [CNT_W-1:0] cnt_q;
   logic             last_col;

   assign cap       = (state == ST_IDLE) && line_start;
   assign load      = (state == ST_FETCH) && font_valid;
   assign active    = (state == ST_SHIFT);
   assign font_req  = (state == ST_FETCH);
   assign line_done = (state == ST_DONE);
   assign last_col  = (col == (cnt_q - 1'b1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         col   <= '0;
         cnt_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (line_start) begin
                  cnt_q <= char_count;
                  col   <= '0;
                  state <= (char_count == '0) ? ST_DONE : ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (font_valid) state <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (col_end) begin
                  if (last_col) begin
                     state <= ST_DONE;
                  end else begin
                     col   <= col + 1'b1;
                     state <= ST_FETCH;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/osd_ser_width.sv
module osd_ser_width #(
   parameter int MASK_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic [MASK_W-1:0] mask_in,
   input  logic [CNT_W-1:0]  col,
   output logic              dbl
);
   localparam int MIDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;

   logic [MASK_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (rst)      mask_q <= '0;
      else if (cap) mask_q <= mask_in;
   end

   generate
      if ((1 << CNT_W) > MASK_W) begin : g_limited
         localparam logic [CNT_W-1:0] LIM = CNT_W'(MASK_W);
         assign dbl = (col < LIM) && mask_q[MIDX_W'(col)];
      end else begin : g_full
         assign dbl = mask_q[MIDX_W'(col)];
      end
   endgenerate
endmodule

// File: rtl/osd_ser_shift.sv
module osd_ser_shift #(
   parameter int FONT_W    = 12,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [FONT_W-1:0] slice,
   input  logic              dbl,
   input  logic              active,
   input  logic              pix_en,
   output logic              pix_out,
   output logic              pix_valid,
   output logic              col_end
);
   localparam int BIT_W = $clog2(FONT_W);
   localparam logic [BIT_W-1:0] LAST = BIT_W'(FONT_W - 1);

   logic [FONT_W-1:0] sreg, sreg_nx;
   logic [BIT_W-1:0]  bit_cnt;
   logic              rep, dbl_q, head, step, advance;

   generate
      if (MSB_FIRST) begin : g_msb
         assign head    = sreg[FONT_W-1];
         assign sreg_nx = {sreg[FONT_W-2:0], 1'b0};
      end else begin : g_lsb
         assign head    = sreg[0];
         assign sreg_nx = {1'b0, sreg[FONT_W-1:1]};
      end
   endgenerate

   assign step    = active && pix_en;
   assign advance = !dbl_q || rep;
   assign col_end = step && advance && (bit_cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg      <= '0;
         bit_cnt   <= '0;
         rep       <= 1'b0;
         dbl_q     <= 1'b0;
         pix_out   <= 1'b0;
         pix_valid <= 1'b0;
      end else begin
         if (load) begin
            sreg    <= slice;
            bit_cnt <= '0;
            rep     <= 1'b0;
            dbl_q   <= dbl;
         end else if (step) begin
            if (advance) begin
               sreg    <= sreg_nx;
               bit_cnt <= bit_cnt + 1'b1;
               rep     <= 1'b0;
            end else begin
               rep <= 1'b1;
            end
         end
         pix_valid <= step;
         pix_out   <= step && head;
      end
   end
endmodule

// File: rtl/osd_row_serializer.sv
module osd_row_serializer #(
   parameter int FONT_W = 12,
   parameter int MASK_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_en,
   input  logic              line_start,
   input  logic [MASK_W-1:0] dbl_mask,
   input  logic [CNT_W-1:0]  char_count,
   output logic              font_req,
   output logic [CNT_W-1:0]  font_idx,
   input  logic [FONT_W-1:0] font_data,
   input  logic              font_valid,
   output logic              pix_out,
   output logic              pix_valid,
   output logic              line_done
);
   generate
      if (FONT_W < 2) begin : g_bad_font
         $error("FONT_W must be at least 2");
      end
      if (MASK_W < 1) begin : g_bad_mask
         $error("MASK_W must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
   endgenerate

   logic [CNT_W-1:0] col;
   logic cap, load, active, col_end, dbl;

   osd_ser_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst(rst), .line_start(line_start), .char_count(char_count),
      .font_valid(font_valid), .col_end(col_end), .col(col), .cap(cap),
      .load(load), .active(active), .font_req(font_req), .line_done(line_done)
   );

   osd_ser_width #(.MASK_W(MASK_W), .CNT_W(CNT_W)) u_width (
      .clk(clk), .rst(rst), .cap(cap), .mask_in(dbl_mask), .col(col), .dbl(dbl)
   );

   osd_ser_shift #(.FONT_W(FONT_W), .MSB_FIRST(1'b1)) u_shift (
      .clk(clk), .rst(rst), .load(load), .slice(font_data), .dbl(dbl),
      .active(active), .pix_en(pix_en), .pix_out(pix_out),
      .pix_valid(pix_valid), .col_end(col_end)
   );

   assign font_idx = col;
endmodule

// File: rtl/osd_ser_chk.sv
module osd_ser_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             pix_en,
   input logic             pix_out,
   input logic             pix_valid,
   input logic             line_done,
   input logic             font_req,
   input logic             font_valid,
   input logic [CNT_W-1:0] font_idx
);
   p_valid_follows_en_r6: assert property (@(posedge clk) disable iff (rst)
      pix_valid |-> $past(pix_en));

   p_low_when_invalid_r6: assert property (@(posedge clk) disable iff (rst)
      !pix_valid |-> !pix_out);

   p_idx_held_r5: assert property (@(posedge clk) disable iff (rst)
      (font_req && !font_valid) |=> (font_req && $stable(font_idx)));

   p_quiet_in_fetch_r5: assert property (@(posedge clk) disable iff (rst)
      (font_req && $past(font_req)) |-> !pix_valid);

   p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
      line_done |=> !line_done);

   p_idle_after_done_r7: assert property (@(posedge clk) disable iff (rst)
      line_done |=> (!font_req && !pix_valid));
endmodule

bind osd_row_serializer osd_ser_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .pix_en(pix_en), .pix_out(pix_out),
   .pix_valid(pix_valid), .line_done(line_done), .font_req(font_req),
   .font_valid(font_valid), .font_idx(font_idx)
);

// File: tb/sim_osd_row_serializer.sv
module sim_osd_row_serializer;
   localparam int FONT_W = 12;
   localparam int MASK_W = 32;
   localparam int CNT_W  = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pix_en = 1'b0;
   logic line_start = 1'b0;
   logic [MASK_W-1:0] dbl_mask = '0;
   logic [CNT_W-1:0] char_count = '0;
   logic font_req;
   logic [CNT_W-1:0] font_idx;
   logic [FONT_W-1:0] font_data = '0;
   logic font_valid = 1'b0;
   logic pix_out, pix_valid, line_done;

   always #5 clk = ~clk;

   osd_row_serializer #(.FONT_W(FONT_W), .MASK_W(MASK_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst(rst), .pix_en(pix_en), .line_start(line_start),
      .dbl_mask(dbl_mask), .char_count(char_count), .font_req(font_req),
      .font_idx(font_idx), .font_data(font_data), .font_valid(font_valid),
      .pix_out(pix_out), .pix_valid(pix_valid), .line_done(line_done)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit exp_q[$];
   string cur_tag = "R2";
   int cur_seed = 0;
   int cur_count = 0;
   int exp_col = 0;
   int fetch_delay = 0;
   int wait_cnt = 0;
   int en_mode = 0;
   bit zero_line = 1'b0;
   bit flushing = 1'b1;
   int done_seen = 0;
   int start_cyc = 0;
   bit prev_done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [11:0] font_fn(int c, int seed);
      return 12'((c * 173 + seed * 59) ^ (c << 5) ^ 'hA5C);
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor, font responder and enable generator, all at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (!flushing) begin
            if (pix_valid) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R9", "unexpected pixel", 1, 0);
               end else begin
                  bit e;
                  e = exp_q.pop_front();
                  check(pix_out == e, cur_tag, "pixel value", int'(pix_out), int'(e));
               end
            end else if (pix_out) begin
               check(1'b0, "R6", "pix_out high without pix_valid", 1, 0);
            end
            if (prev_done) begin
               check(!line_done && !font_req && !pix_valid, "R7",
                     "block not idle after line_done",
                     int'({line_done, font_req, pix_valid}), 0);
            end
            if (line_done) begin
               done_seen++;
               if (zero_line) begin
                  check(cyc == start_cyc + 1, "R8", "line_done cycle", cyc, start_cyc + 1);
                  check(!pix_valid, "R8", "pixel on empty line", int'(pix_valid), 0);
               end else begin
                  check(pix_valid, "R7", "line_done not with last pixel", int'(pix_valid), 1);
                  check(exp_q.size() == 0, "R7", "pixels left at line_done", exp_q.size(), 0);
                  check(exp_col == cur_count, "R5", "columns fetched", exp_col, cur_count);
               end
            end
            prev_done = line_done;
            // font responder
            if (font_req && !font_valid) begin
               if (wait_cnt >= fetch_delay) begin
                  if (exp_col >= cur_count) begin
                     check(1'b0, zero_line ? "R8" : "R9", "unexpected fetch",
                           int'(font_idx), cur_count);
                  end
                  check(int'(font_idx) == exp_col, "R5", "font_idx", int'(font_idx), exp_col);
                  font_data  = font_fn(exp_col, cur_seed);
                  font_valid = 1'b1;
                  exp_col++;
                  wait_cnt = 0;
               end else begin
                  wait_cnt++;
               end
            end else begin
               font_valid = 1'b0;
               wait_cnt   = 0;
            end
         end else begin
            prev_done  = 1'b0;
            font_valid = 1'b0;
            wait_cnt   = 0;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (en_mode)
            0: pix_en = 1'b1;
            1: pix_en = (cyc % 3) != 0;
            default: pix_en = lfsr[0];
         endcase
      end
   end

   task automatic push_expected(int count, logic [MASK_W-1:0] mask, int seed);
      for (int c = 0; c < count; c++) begin
         logic [11:0] s;
         bit d;
         s = font_fn(c, seed);
         d = (c < MASK_W) ? mask[c] : 1'b0;
         for (int b = FONT_W - 1; b >= 0; b--) begin
            exp_q.push_back(s[b]);
            if (d) exp_q.push_back(s[b]);
         end
      end
   endtask

   task automatic run_line(int count, logic [MASK_W-1:0] mask, int seed, int mode,
                           int delay, string tag, int post_count,
                           logic [MASK_W-1:0] post_mask, int restart_at);
      int d0;
      int n;
      @(negedge clk);
      cur_tag = tag; cur_seed = seed; cur_count = count; exp_col = 0;
      fetch_delay = delay; en_mode = mode; zero_line = (count == 0);
      push_expected(count, mask, seed);
      d0 = done_seen;
      dbl_mask = mask; char_count = CNT_W'(count); line_start = 1'b1;
      start_cyc = cyc;
      @(negedge clk);
      line_start = 1'b0;
      dbl_mask = post_mask; char_count = CNT_W'(post_count);
      n = 0;
      while (done_seen == d0 && n < 20000) begin
         @(negedge clk);
         n++;
         if (restart_at != 0 && n == restart_at) line_start = 1'b1;
         else line_start = 1'b0;
      end
      line_start = 1'b0;
      check(done_seen == d0 + 1, tag, "line completion count", done_seen - d0, 1);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, tag, "pixels outstanding", exp_q.size(), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!pix_valid && !pix_out && !line_done && !font_req, "R10", "reset outputs",
            int'({pix_valid, pix_out, line_done, font_req}), 0);
      rst = 1'b0;
      flushing = 1'b0;
      repeat (2) @(negedge clk);

      // R2: normal width, MSB first
      run_line(5, '0, 1, 0, 0, "R2", 5, '0, 0);
      // R3: all double width, gapped enable
      run_line(4, '1, 2, 1, 1, "R3", 4, '1, 0);
      // R4: columns past 32 stay normal
      run_line(36, '1, 3, 0, 0, "R4", 36, '1, 0);
      // R4/R3: mixed mask, random enable, slow fetch
      run_line(40, 32'hA5A5_0F0F, 4, 2, 3, "R4", 40, 32'hA5A5_0F0F, 0);
      // R5: long fetch wait
      run_line(3, 32'h2, 5, 0, 6, "R5", 3, 32'h2, 0);
      // R1: changes during the line are not used; next line uses them
      run_line(3, '0, 6, 0, 1, "R1", 6, 32'h0000_0015, 0);
      run_line(6, 32'h0000_0015, 7, 1, 0, "R1", 6, 32'h0000_0015, 0);
      // R9: start while running is ignored
      run_line(4, 32'h9, 8, 0, 2, "R9", 4, 32'h9, 20);
      // R8: empty line
      run_line(0, '1, 9, 0, 0, "R8", 0, '1, 0);

      // R10: reset drops a partial line
      begin
         int d0;
         @(negedge clk);
         cur_tag = "R10"; cur_seed = 10; cur_count = 5; exp_col = 0;
         fetch_delay = 0; en_mode = 0; zero_line = 1'b0;
         push_expected(5, 32'h3, 10);
         dbl_mask = 32'h3; char_count = 8'd5; line_start = 1'b1;
         @(negedge clk);
         line_start = 1'b0;
         repeat (30) @(negedge clk);
         d0 = done_seen;
         flushing = 1'b1;
         rst = 1'b1;
         exp_q.delete();
         repeat (2) @(negedge clk);
         check(!pix_valid && !pix_out && !line_done && !font_req, "R10",
               "outputs during reset", int'({pix_valid, pix_out, line_done, font_req}), 0);
         rst = 1'b0;
         cur_count = 0; exp_col = 0;
         flushing = 1'b0;
         repeat (40) @(negedge clk);
         check(done_seen == d0, "R10", "line_done after abort", done_seen - d0, 0);
      end
      // normal line after the abort
      run_line(2, 32'h1, 11, 0, 0, "R10", 2, 32'h1, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule